// File: doc/BRIEF.md
# Fixed-Point Divider with Valid/Ready Handshake

This block divides a fixed-point dividend by a fixed-point divisor and returns a fixed-point quotient, truncated toward zero. The dividend, the divisor and the quotient each have their own format, set by parameters. A format is a signedness, a total word length `WL` and an integer word length `IWL`. A code `c` in a format stands for `c / 2^(WL-IWL)`. Signed codes are two's complement.

Operands enter over a valid/ready handshake and results leave over a second one, so downstream can apply backpressure. The per-operation `sat_mode` input picks what an out-of-range result becomes: the nearest range limit, or the low bits of the exact truncated quotient. A divide-by-zero is reported as an overflow. If downstream never stalls, tie `out_ready` to 1.

The divider first aligns the operand magnitudes. The dividend magnitude is shifted left by `max(S,0)` and the divisor magnitude by `max(-S,0)`, where `S = QF + YF - XF` and each `F` is `WL-IWL`. This places the binary point of the integer quotient at the output format. A restoring loop then produces one quotient bit per clock over `NW = X_WL + max(S,0)` cycles, and the sign is applied at the end.

The control FSM has four states:
- `ST_IDLE` takes operands. It moves to `ST_RUN` on a handshake, or to `ST_PACK` when the divisor is zero.
- `ST_RUN` iterates and moves to `ST_PACK` after its last step.
- `ST_PACK` signs, range-checks and registers the result, then moves to `ST_HOLD`.
- `ST_HOLD` presents the result and returns to `ST_IDLE` once `out_ready` is high.

Top module: `fxdiv`

## Requirements
- R1: After a synchronous active-high reset, `in_ready` is 1, `out_valid` is 0 and `ovf_out` is 0.
- R2: An operand pair (with its `sat_mode`) is taken only at a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 from that edge until the result has been taken.
- R3: For a non-zero divisor with the result in range, `q_out` is the exact quotient `x/y` truncated to the output format, and `ovf_out` is 0.
- R4: Truncation is toward zero for negative results too. For example, -1/3 in the 16-bit Q8.8 format gives code -85, not -86.
- R5: `ovf_out` is 1 exactly when the truncated quotient lies outside the output range, or when the divisor is zero. A result equal to a range limit is not an overflow.
- R6: When `sat_mode` is 1 and a non-zero divisor overflows, `q_out` is the most positive code for a positive quotient and the most negative code for a negative quotient.
- R7: When `sat_mode` is 0 and the result overflows, `q_out` is the low `Q_WL` bits of the two's complement truncated quotient.
- R8: A zero divisor gives `ovf_out` = 1. When `sat_mode` is 1, `q_out` is the most negative code for a negative dividend and the most positive code otherwise. When `sat_mode` is 0, `q_out` is 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `q_out` and `ovf_out` hold their values.
- R10: `out_valid` rises `NW+1` clock edges after the accepting edge for a non-zero divisor, and 1 edge after it for a zero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take an operand pair |
| x_in | input | X_WL | Dividend code |
| y_in | input | Y_WL | Divisor code |
| sat_mode | input | 1 | 1: saturate on overflow, 0: wrap |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result (tie to 1 when unused) |
| q_out | output | Q_WL | Quotient code |
| ovf_out | output | 1 | Overflow or divide-by-zero |

## Verification
The hardest case to reach from the ports is an operand pair that sits on `in_valid` while an earlier division is still iterating or its result is being held by backpressure. A premature capture there would silently corrupt the next result. The scoreboard driver keeps each new pair asserted until `in_ready` returns, and downstream applies random stalls. Any early capture therefore shows up as a wrong value or a wrong latency. Directed operands place quotients exactly on the range limits and just beyond them, so the overflow edge is hit in both directions and in both modes.

// File: rtl/fxdiv_pkg.sv
package fxdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_PACK,
        ST_HOLD
    } fxdiv_state_e;

    function automatic int pos_part(input int v);
        return (v > 0) ? v : 0;
    endfunction

endpackage

// File: rtl/fxdiv_align.sv
module fxdiv_align #(
    parameter bit X_SIGNED = 1'b1,
    parameter int X_WL     = 16,
    parameter bit Y_SIGNED = 1'b1,
    parameter int Y_WL     = 16,
    parameter int LS       = 8,
    parameter int RS       = 0,
    parameter int NW       = X_WL + LS,
    parameter int DW       = Y_WL + RS
) (
    input  logic [X_WL-1:0] x,
    input  logic [Y_WL-1:0] y,
    output logic [NW-1:0]   num,
    output logic [DW-1:0]   den,
    output logic            q_neg,
    output logic            x_neg,
    output logic            y_zero
);
    logic            y_neg;
    logic [X_WL-1:0] x_mag;
    logic [Y_WL-1:0] y_mag;

    always_comb begin
        x_neg  = X_SIGNED && x[X_WL-1];
        y_neg  = Y_SIGNED && y[Y_WL-1];
        x_mag  = x_neg ? (~x + 1'b1) : x;
        y_mag  = y_neg ? (~y + 1'b1) : y;
        num    = NW'(x_mag) << LS;
        den    = DW'(y_mag) << RS;
        q_neg  = x_neg ^ y_neg;
        y_zero = (y == '0);
    end

endmodule

// File: rtl/fxdiv_core.sv
module fxdiv_core #(
    parameter int NW = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          load,
    input  logic          step,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic [NW-1:0] quo
);
    logic [DW:0]   rem_q;
    logic [DW-1:0] den_q;
    logic [NW-1:0] shf_q;
    logic [DW:0]   trial;
    logic          fits;

    always_comb begin
        trial = {rem_q[DW-1:0], shf_q[NW-1]};
        fits  = (trial >= {1'b0, den_q});
    end

    always_ff @(posedge clk) begin
        if (load) begin
            rem_q <= '0;
            den_q <= den;
            shf_q <= num;
        end else if (step) begin
            rem_q <= fits ? (trial - {1'b0, den_q}) : trial;
            shf_q <= {shf_q[NW-2:0], fits};
        end
    end

    assign quo = shf_q;

    // R3
    rem_below_den_chk: assert property (@(posedge clk)
        (step && !load && den_q != '0) |=> (rem_q < {1'b0, den_q}));

endmodule

// File: rtl/fxdiv_pack.sv
module fxdiv_pack #(
    parameter bit Q_SIGNED = 1'b1,
    parameter int Q_WL     = 16,
    parameter int NW       = 24
) (
    input  logic [NW-1:0]   mag,
    input  logic            q_neg,
    input  logic            x_neg,
    input  logic            y_zero,
    input  logic            sat,
    output logic [Q_WL-1:0] q,
    output logic            ovf
);
    localparam int CW = ((NW > Q_WL) ? NW : Q_WL) + 1;
    localparam logic [CW-1:0] POS_LIM = Q_SIGNED ? ((CW'(1) << (Q_WL-1)) - CW'(1))
                                                 : ((CW'(1) << Q_WL) - CW'(1));
    localparam logic [CW-1:0] NEG_LIM = Q_SIGNED ? (CW'(1) << (Q_WL-1)) : '0;
    localparam logic [Q_WL-1:0] QMAX = Q_SIGNED ? {1'b0, {(Q_WL-1){1'b1}}} : '1;
    localparam logic [Q_WL-1:0] QMIN = Q_SIGNED ? {1'b1, {(Q_WL-1){1'b0}}} : '0;

    logic [CW-1:0]   magx;
    logic            neg_res;
    logic            range_bad;
    logic [Q_WL-1:0] wrapped;

    always_comb begin
        magx      = CW'(mag);
        neg_res   = q_neg && (mag != '0);
        range_bad = neg_res ? (magx > NEG_LIM) : (magx > POS_LIM);
        wrapped   = neg_res ? (~magx[Q_WL-1:0] + 1'b1) : magx[Q_WL-1:0];
        ovf       = y_zero || range_bad;
        if (y_zero)
            q = sat ? (x_neg ? QMIN : QMAX) : '0;
        else if (range_bad && sat)
            q = neg_res ? QMIN : QMAX;
        else
            q = wrapped;
    end

endmodule

// File: rtl/fxdiv.sv
module fxdiv #(
    parameter bit X_SIGNED = 1'b1,
    parameter int X_WL     = 16,
    parameter int X_IWL    = 8,
    parameter bit Y_SIGNED = 1'b1,
    parameter int Y_WL     = 16,
    parameter int Y_IWL    = 8,
    parameter bit Q_SIGNED = 1'b1,
    parameter int Q_WL     = 16,
    parameter int Q_IWL    = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [X_WL-1:0] x_in,
    input  logic [Y_WL-1:0] y_in,
    input  logic            sat_mode,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [Q_WL-1:0] q_out,
    output logic            ovf_out
);
    import fxdiv_pkg::*;

    localparam int XF   = X_WL - X_IWL;
    localparam int YF   = Y_WL - Y_IWL;
    localparam int QF   = Q_WL - Q_IWL;
    localparam int SH   = QF + YF - XF;
    localparam int LS   = pos_part(SH);
    localparam int RS   = pos_part(-SH);
    localparam int NW   = X_WL + LS;
    localparam int DW   = Y_WL + RS;
    localparam int CNTW = $clog2(NW + 1);
    localparam logic [Q_WL-1:0] QMAX = Q_SIGNED ? {1'b0, {(Q_WL-1){1'b1}}} : '1;
    localparam logic [Q_WL-1:0] QMIN = Q_SIGNED ? {1'b1, {(Q_WL-1){1'b0}}} : '0;

    fxdiv_state_e state_q, state_d;

    logic [NW-1:0]   al_num, quo;
    logic [DW-1:0]   al_den;
    logic            al_qneg, al_xneg, al_yzero;
    logic            qneg_q, xneg_q, yzero_q, sat_q;
    logic [CNTW-1:0] cnt_q;
    logic            take, load, step, last;
    logic [Q_WL-1:0] pk_q, q_q;
    logic            pk_ovf, ovf_q;

    fxdiv_align #(
        .X_SIGNED(X_SIGNED), .X_WL(X_WL),
        .Y_SIGNED(Y_SIGNED), .Y_WL(Y_WL),
        .LS(LS), .RS(RS), .NW(NW), .DW(DW)
    ) u_align (
        .x(x_in), .y(y_in), .num(al_num), .den(al_den),
        .q_neg(al_qneg), .x_neg(al_xneg), .y_zero(al_yzero)
    );

    fxdiv_core #(.NW(NW), .DW(DW)) u_core (
        .clk(clk), .load(load), .step(step),
        .num(al_num), .den(al_den), .quo(quo)
    );

    fxdiv_pack #(.Q_SIGNED(Q_SIGNED), .Q_WL(Q_WL), .NW(NW)) u_pack (
        .mag(quo), .q_neg(qneg_q), .x_neg(xneg_q), .y_zero(yzero_q),
        .sat(sat_q), .q(pk_q), .ovf(pk_ovf)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take)      state_d = al_yzero ? ST_PACK : ST_RUN;
            ST_RUN:  if (last)      state_d = ST_PACK;
            ST_PACK:                state_d = ST_HOLD;
            ST_HOLD: if (out_ready) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        step      = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready  = 1'b1;
            ST_RUN:  step      = 1'b1;
            ST_PACK: ;
            ST_HOLD: out_valid = 1'b1;
            default: ;
        endcase
        take = in_ready && in_valid;
        load = take;
        last = step && (cnt_q == CNTW'(NW - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
            q_q   <= '0;
        end else begin
            if (take) begin
                qneg_q  <= al_qneg;
                xneg_q  <= al_xneg;
                yzero_q <= al_yzero;
                sat_q   <= sat_mode;
                cnt_q   <= '0;
            end else if (step) begin
                cnt_q   <= cnt_q + 1'b1;
            end
            if (state_q == ST_PACK) begin
                q_q   <= pk_q;
                ovf_q <= pk_ovf;
            end
        end
    end

    assign q_out   = q_q;
    assign ovf_out = ovf_q;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (in_ready && !out_valid && !ovf_out));

    // R2
    busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(q_out) && $stable(ovf_out)));

    // R8
    div_zero_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && yzero_q) |-> ovf_out);

    // R6
    sat_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ovf_out && sat_q) |-> (q_out == QMAX || q_out == QMIN));

endmodule

// File: tb/fxdiv_tb.sv
module fxdiv_tb;

    localparam int NW_EXP = 16 + (8 + 8 - 8);   // R10: NW for the default formats

    typedef struct {
        logic [15:0] q;
        logic        ovf;
        longint      acc;
        logic        yz;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] x_in = '0;
    logic [15:0] y_in = '0;
    logic        sat_mode = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] q_out;
    logic        ovf_out;

    int     n_chk = 0;
    int     n_bad = 0;
    longint cyc = 0;
    bit     bp_en = 1'b0;
    bit     done = 1'b0;
    exp_t   sb[$];

    always #4 clk = ~clk;

    fxdiv u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .x_in(x_in), .y_in(y_in), .sat_mode(sat_mode),
        .out_valid(out_valid), .out_ready(out_ready),
        .q_out(q_out), .ovf_out(ovf_out)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        out_ready <= bp_en ? 1'($urandom % 2) : 1'b1;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [15:0] x, input logic [15:0] y, input logic sat);
        exp_t   e;
        longint num, qv;
        e.yz = (y == 0);
        if (e.yz) begin
            e.ovf = 1'b1;
            e.q   = sat ? (($signed(x) < 0) ? 16'h8000 : 16'h7FFF) : 16'h0000;
        end else begin
            num   = longint'($signed(x)) * 256;
            qv    = num / longint'($signed(y));  // truncates toward zero
            e.ovf = (qv > 32767) || (qv < -32768);
            if (e.ovf && sat) e.q = (qv > 0) ? 16'h7FFF : 16'h8000;
            else              e.q = 16'(qv);
        end
        e.acc = 0;
        return e;
    endfunction

    // driver: called just after a falling edge
    task automatic send(input logic [15:0] x, input logic [15:0] y, input logic sat);
        exp_t e;
        e = model(x, y, sat);
        x_in = x; y_in = y; sat_mode = sat; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        e.acc = cyc + 1;
        sb.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
        x_in = ~x;   // new garbage while busy must not be taken (R2)
    endtask

    // monitor
    logic        pv = 1'b0, pr = 1'b0, povf = 1'b0;
    logic [15:0] pq = '0;
    always @(negedge clk) begin
        if (!rst) begin
            if (pv && !pr) begin
                // R9
                check(out_valid && q_out == pq && ovf_out == povf, "R9",
                      longint'(q_out), longint'(pq));
            end
            if (out_valid) begin
                // R2
                check(!in_ready, "R2", longint'(in_ready), 0);
                if (!pv) begin
                    if (sb.size() == 0)
                        check(1'b0, "R2", 1, 0);
                    else
                        // R10
                        check(cyc == sb[0].acc + (sb[0].yz ? 1 : NW_EXP + 1), "R10",
                              cyc - sb[0].acc, sb[0].yz ? 1 : NW_EXP + 1);
                end
                if (out_ready && sb.size() != 0) begin
                    exp_t e;
                    e = sb.pop_front();
                    // R3 R4 R5 R6 R7 R8
                    check(q_out == e.q, "R3/R4/R6/R7/R8 value", longint'($signed(q_out)),
                          longint'($signed(e.q)));
                    check(ovf_out == e.ovf, "R5 overflow flag", longint'(ovf_out),
                          longint'(e.ovf));
                end
            end
            pv = out_valid; pr = out_ready; pq = q_out; povf = ovf_out;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(in_ready && !out_valid && !ovf_out, "R1", longint'({in_ready, out_valid, ovf_out}), 4);

        // R3
        send(16'd768, 16'd384, 1'b1);
        send(16'd256, 16'd768, 1'b1);
        // R4
        send(-16'sd256, 16'd768, 1'b1);
        send(16'd256, -16'sd768, 1'b0);
        send(-16'sd256, -16'sd768, 1'b1);
        send(-16'sd1, 16'd3, 1'b1);
        // R5 R6 R7
        send(16'd25600, 16'd128, 1'b1);
        send(16'd25600, 16'd128, 1'b0);
        send(-16'sd25600, 16'd128, 1'b1);
        send(-16'sd25600, 16'd128, 1'b0);
        send(-16'sd16384, 16'd128, 1'b1);   // exactly most negative
        send(16'd16384, 16'd128, 1'b1);     // one past most positive
        send(16'h8000, -16'sd256, 1'b1);
        send(16'h8000, -16'sd256, 1'b0);
        // R8
        send(16'd5, 16'd0, 1'b1);
        send(-16'sd5, 16'd0, 1'b1);
        send(16'd0, 16'd0, 1'b1);
        send(-16'sd5, 16'd0, 1'b0);
        // random with backpressure (R2 R9)
        bp_en = 1'b1;
        for (int i = 0; i < 60; i++) begin
            logic [15:0] rx, ry;
            rx = 16'($urandom);
            ry = (i % 7 == 0) ? 16'd0 : 16'($urandom >> (i % 12));
            send(rx, ry, 1'($urandom % 2));
        end
        while (sb.size() != 0 || out_valid) @(negedge clk);
        bp_en = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", sb.size(), 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule